// File: doc/BRIEF.md
# Programmable Memory Pattern Sequencer

This block drives the control strobes of an external memory from a small, writable pattern store. Each stored word gives one bus cycle's worth of strobe levels (one chip-select line and six general-purpose lines) plus four control flags: end of routine, wait enable, address step and transfer acknowledge. A bus request names the index of a routine's first word and a starting burst address. The sequencer then runs one word per clock, moving to the next higher index, until it reaches a word flagged as the end of the routine.

A second request may be queued while a routine runs. Its first word follows the last word of the running routine with no gap. With nothing queued, every strobe returns high. An external wait input is brought in through a synchronizer. A word with wait enable set stalls the sequencer for as long as the synchronized wait stays high. While it stalls the strobes hold their levels and no transfer is acknowledged. The burst address still steps at most once for that word. The store can only be written while the sequencer is idle.

Top module: `mem_pattern_seq`

## Requirements
- R1: After reset the block is idle (`busy`=0), `cs_n`=1, `gpl` all ones, `xfer_ack`=0, `burst_addr`=0 and `req_ready`=1.
- R2: A stored word decodes as bit 0 chip-select level, bits 6:1 general-purpose levels, bit 7 end of routine, bit 8 wait enable, bit 9 address step, bit 10 transfer acknowledge; higher bits are ignored. A request accepted at clock edge k makes `busy` high after edge k+1. The levels of its first word appear after edge k+2, and the following words come one per clock at increasing (wrapping) index.
- R3: After the levels of an end-of-routine word appear, and when no request is queued, the next cycle shows `cs_n`=1, all `gpl` high and `busy`=0.
- R4: When a request is queued as an end-of-routine word executes, the levels of the queued routine's first word appear on the very next cycle.
- R5: `wait_in` passes through two flip-flops. A value applied before edge k is what the sequencer acts on in the cycle after edge k+1.
- R6: When the current word has wait enable set and the synchronized wait is high, the index does not advance, `cs_n` and `gpl` keep their previous levels, and `xfer_ack` is 0.
- R7: Wait enable has no effect in a word that also has end of routine set.
- R8: A word with the address step flag adds exactly one to `burst_addr`, however many cycles that word is frozen.
- R9: `xfer_ack` pulses high for one cycle for each executed word with transfer acknowledge set, and never for frozen cycles or while idle.
- R10: Writes to the pattern store take effect only while `busy` is 0 and are ignored while a routine runs.
- R11: A routine starts with `burst_addr` loaded from the request's address. `req_ready` is 0 while a request is queued and not yet started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Pattern store write strobe |
| wr_idx | input | IDX_W | Pattern store write index |
| wr_data | input | WORD_W | Pattern word to store |
| req_valid | input | 1 | Request present |
| req_idx | input | IDX_W | Index of the routine's first word |
| req_addr | input | ADDR_W | Starting burst address |
| req_ready | output | 1 | Request slot free |
| wait_in | input | 1 | Asynchronous wait from the memory |
| cs_n | output | 1 | Chip-select strobe level |
| gpl | output | 6 | General-purpose strobe levels |
| xfer_ack | output | 1 | Data transfer acknowledge pulse |
| burst_addr | output | ADDR_W | Burst address counter |
| busy | output | 1 | Routine in progress |

## Verification
The bench builds the block with a 16-word store (IDX_W=4) and an 8-bit address (ADDR_W=8). With these sizes random requests land on every word, routines that start near the top of the store wrap around to index 0, and the burst counter rolls over from 255 to 0 within the run. Directed routines cover the cases that random traffic reaches only rarely: a long freeze on a word that also steps the address, wait enable on a final word, back-to-back routines, and writes attempted mid-routine. These sit alongside thousands of random cycles with a busy wait line.

// File: rtl/mps_pkg.sv
package mps_pkg;

    localparam int GPL_N = 6;

    // Decoded pattern word, low bits of the stored word (bit 0 = chip select)
    typedef struct packed {
        logic             xfer;     // bit 10
        logic             step;     // bit 9
        logic             hold_en;  // bit 8
        logic             fin;      // bit 7
        logic [GPL_N-1:0] gp;       // bits 6:1
        logic             cs;       // bit 0
    } mps_word_t;

    localparam int FIELD_W = $bits(mps_word_t);

endpackage

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram #(
    parameter int IDX_W  = 6,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/mps_wait_sync.sv
module mps_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/mps_burst_ctr.sv
module mps_burst_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_val;
        end else if (inc) begin
            addr_d = addr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq
    import mps_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int WORD_W      = 32,
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              wait_in,
    output logic              cs_n,
    output logic [GPL_N-1:0]  gpl,
    output logic              xfer_ack,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              busy
);
    typedef struct packed {
        logic              run;
        logic [IDX_W-1:0]  pc;
        logic              pend;
        logic [IDX_W-1:0]  pidx;
        logic [ADDR_W-1:0] paddr;
        logic              cs;
        logic [GPL_N-1:0]  gp;
        logic              ack;
        logic              stepped;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [WORD_W-1:0] rd_data;
    mps_word_t         cur;
    logic              wait_s;
    logic              freeze;
    logic              ctr_load;
    logic              ctr_inc;

    mps_pattern_ram #(.IDX_W(IDX_W), .WORD_W(WORD_W)) i_ram (
        .clk     (clk),
        .we      (wr_en && !st_q.run),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (st_q.pc),
        .rd_data (rd_data)
    );

    mps_wait_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (wait_in),
        .sync_out (wait_s)
    );

    mps_burst_ctr #(.ADDR_W(ADDR_W)) i_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (st_q.paddr),
        .inc      (ctr_inc),
        .addr     (burst_addr)
    );

    assign cur = mps_word_t'(rd_data[FIELD_W-1:0]);

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        freeze   = 1'b0;
        ctr_load = 1'b0;
        ctr_inc  = 1'b0;

        if (!st_q.run) begin
            // idle: every strobe released
            st_d.cs = 1'b1;
            st_d.gp = '1;
            if (st_q.pend) begin
                st_d.run     = 1'b1;
                st_d.pc      = st_q.pidx;
                st_d.pend    = 1'b0;
                st_d.stepped = 1'b0;
                ctr_load     = 1'b1;
            end
        end else begin
            freeze  = cur.hold_en && !cur.fin && wait_s;
            ctr_inc = cur.step && !st_q.stepped;
            if (freeze) begin
                st_d.stepped = st_q.stepped | cur.step;
            end else begin
                st_d.cs      = cur.cs;
                st_d.gp      = cur.gp;
                st_d.ack     = cur.xfer;
                st_d.stepped = 1'b0;
                if (cur.fin) begin
                    if (st_q.pend) begin
                        st_d.pc   = st_q.pidx;
                        st_d.pend = 1'b0;
                        ctr_load  = 1'b1;
                    end else begin
                        st_d.run = 1'b0;
                    end
                end else begin
                    st_d.pc = st_q.pc + IDX_W'(1);
                end
            end
        end

        if (req_valid && !st_q.pend) begin
            st_d.pend  = 1'b1;
            st_d.pidx  = req_idx;
            st_d.paddr = req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.run     <= 1'b0;
            st_q.pc      <= '0;
            st_q.pend    <= 1'b0;
            st_q.pidx    <= '0;
            st_q.paddr   <= '0;
            st_q.cs      <= 1'b1;
            st_q.gp      <= '1;
            st_q.ack     <= 1'b0;
            st_q.stepped <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.pend;
    assign cs_n      = st_q.cs;
    assign gpl       = st_q.gp;
    assign xfer_ack  = st_q.ack;
    assign busy      = st_q.run;

endmodule

// File: rtl/mps_chk.sv
module mps_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              cs_n,
    input logic [5:0]        gpl,
    input logic              xfer_ack,
    input logic [ADDR_W-1:0] burst_addr,
    input logic              wait_in,
    input logic              wait_s,
    input logic              freeze,
    input logic              ctr_load
);
    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!busy) |-> (cs_n && (&gpl) && !xfer_ack));

    // R9
    ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> $past(busy));

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(freeze) |-> ($stable(cs_n) && $stable(gpl) && !xfer_ack));

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !$past(ctr_load)) |->
            (burst_addr == $past(burst_addr) ||
             burst_addr == ADDR_W'($past(burst_addr) + ADDR_W'(1))));

    // R5
    sync_lat_chk: assert property (@(posedge clk) disable iff (rst)
        wait_s |-> $past(wait_in, 2));

endmodule

bind mem_pattern_seq mps_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .cs_n       (cs_n),
    .gpl        (gpl),
    .xfer_ack   (xfer_ack),
    .burst_addr (burst_addr),
    .wait_in    (wait_in),
    .wait_s     (wait_s),
    .freeze     (freeze),
    .ctr_load   (ctr_load)
);

// File: tb/test_mem_pattern_seq.sv
module test_mem_pattern_seq;
    localparam int IDX_W  = 4;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << IDX_W;
    // word fields (R2)
    localparam int B_CS = 0, B_FIN = 7, B_WEN = 8, B_STEP = 9, B_XFER = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              req_valid = 1'b0;
    logic [IDX_W-1:0]  req_idx = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              wait_in = 1'b0;
    logic              cs_n;
    logic [5:0]        gpl;
    logic              xfer_ack;
    logic [ADDR_W-1:0] burst_addr;
    logic              busy;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    mem_pattern_seq #(.IDX_W(IDX_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_mem_pattern_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .req_valid(req_valid), .req_idx(req_idx), .req_addr(req_addr), .req_ready(req_ready),
        .wait_in(wait_in), .cs_n(cs_n), .gpl(gpl), .xfer_ack(xfer_ack),
        .burst_addr(burst_addr), .busy(busy)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [WORD_W-1:0] m_ram [DEPTH];
    logic              m_run, m_pend, m_cs, m_ack, m_stepped, m_s1, m_s2;
    logic [IDX_W-1:0]  m_pc, m_pidx;
    logic [ADDR_W-1:0] m_paddr, m_addr;
    logic [5:0]        m_gp;

    always @(posedge clk) begin
        logic [WORD_W-1:0] w;
        logic frz;
        if (rst) begin
            m_run <= 0; m_pend <= 0; m_cs <= 1; m_gp <= '1; m_ack <= 0;
            m_stepped <= 0; m_s1 <= 0; m_s2 <= 0; m_pc <= '0; m_pidx <= '0;
            m_paddr <= '0; m_addr <= '0;
        end else begin
            m_s1 <= wait_in;
            m_s2 <= m_s1;
            m_ack <= 0;
            // R10: store writes only while idle
            if (wr_en && !m_run) m_ram[wr_idx] <= wr_data;
            w = m_ram[m_pc];
            if (!m_run) begin
                m_cs <= 1; m_gp <= '1;
                if (m_pend) begin
                    m_run <= 1; m_pc <= m_pidx; m_pend <= 0; m_stepped <= 0; m_addr <= m_paddr;
                end
            end else begin
                frz = w[B_WEN] && !w[B_FIN] && m_s2;
                if (w[B_STEP] && !m_stepped) m_addr <= m_addr + 1'b1;
                if (frz) begin
                    m_stepped <= m_stepped | w[B_STEP];
                end else begin
                    m_cs <= w[B_CS]; m_gp <= w[6:1]; m_ack <= w[B_XFER]; m_stepped <= 0;
                    if (w[B_FIN]) begin
                        if (m_pend) begin
                            m_pc <= m_pidx; m_pend <= 0; m_addr <= m_paddr;
                        end else m_run <= 0;
                    end else m_pc <= m_pc + 1'b1;
                end
            end
            if (req_valid && !m_pend) begin
                m_pend <= 1; m_pidx <= req_idx; m_paddr <= req_addr;
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(phase, "cs_n", 32'(cs_n), 32'(m_cs));
            chk(phase, "gpl", 32'(gpl), 32'(m_gp));
            chk(phase, "xfer_ack", 32'(xfer_ack), 32'(m_ack));
            chk(phase, "burst_addr", 32'(burst_addr), 32'(m_addr));
            chk(phase, "busy", 32'(busy), 32'(m_run));
            chk(phase, "req_ready", 32'(req_ready), 32'(!m_pend));
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    function automatic logic [WORD_W-1:0] mkw(bit cs, logic [5:0] gp, bit fin, bit wen, bit step, bit xfer);
        return {21'h0, xfer, step, wen, fin, gp, cs};
    endfunction

    task automatic wr(int idx, logic [WORD_W-1:0] d);
        @(negedge clk); wr_en = 1; wr_idx = IDX_W'(idx); wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic req(int idx, int addr);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_idx = IDX_W'(idx); req_addr = ADDR_W'(addr);
        @(negedge clk); req_valid = 0;
    endtask

    task automatic idle_wait();
        @(negedge clk);
        while (busy || !req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd777));
        repeat (4) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "cs_n", 32'(cs_n), 1);
        chk("R1", "gpl", 32'(gpl), 32'h3f);
        chk("R1", "xfer_ack", 32'(xfer_ack), 0);
        chk("R1", "burst_addr", 32'(burst_addr), 0);
        chk("R1", "req_ready", 32'(req_ready), 1);

        for (int i = 0; i < DEPTH; i++) wr(i, mkw(1, 6'h3f, 1, 0, 0, 0));
        wr(0, mkw(0, 6'h2a, 0, 0, 0, 0));
        wr(1, mkw(0, 6'h15, 0, 1, 1, 0));
        wr(2, mkw(0, 6'h0f, 1, 0, 0, 1) | 32'hfff0_0000); // upper bits ignored (R2)
        wr(3, mkw(0, 6'h33, 1, 1, 1, 1));
        wr(8, mkw(0, 6'h01, 0, 0, 1, 1));
        wr(9, mkw(1, 6'h02, 1, 0, 0, 1));
        wr(15, mkw(0, 6'h07, 0, 0, 1, 0));   // wraps to index 0

        phase = "R2"; req(0, 8'h10); idle_wait();
        phase = "R11"; req(8, 8'hfe); idle_wait();
        // R6 / R8: long freeze on a word that also steps the address
        phase = "R6"; wait_in = 1; req(0, 8'h40);
        repeat (8) @(negedge clk);
        phase = "R5"; wait_in = 0; idle_wait();
        phase = "R7"; wait_in = 1; req(3, 8'h55); idle_wait(); wait_in = 0;
        // R4 back-to-back, R9 acknowledges
        phase = "R4"; req(8, 8'h20); req(0, 8'h30); req(9, 8'h90); idle_wait();
        // R10 writes during a routine are dropped
        phase = "R10";
        wait_in = 1; req(0, 8'h01);
        @(negedge clk); wr_en = 1; wr_idx = 4'd2; wr_data = mkw(1, 6'h00, 1, 0, 0, 0);
        @(negedge clk); wr_en = 0;
        wait_in = 0; idle_wait();
        phase = "R9"; req(2, 8'h02); idle_wait();
        phase = "R3"; req(15, 8'hff); idle_wait();

        // random traffic; every 4th word ends a routine so routines stay short
        phase = "R8";
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            req_valid = ($urandom % 3) == 0;
            req_idx   = IDX_W'($urandom);
            req_addr  = ADDR_W'($urandom);
            if (($urandom % 5) == 0) wait_in = ~wait_in;
            wr_en   = ($urandom % 6) == 0;
            wr_idx  = IDX_W'($urandom);
            wr_data = $urandom;
            if (wr_idx[1:0] == 2'b11) wr_data[B_FIN] = 1'b1;
        end
        @(negedge clk); req_valid = 0; wr_en = 0; wait_in = 0;
        idle_wait();

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule